// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked request port and an external asynchronous static RAM of 256K words by 16 bits with separate enables for each byte. A requester presents one word access at a time: an address, write data, a byte mask and a direction flag, qualified by a valid/ready handshake. The controller then plays out a fixed sequence of phases (setup, strobe, hold, and a bus turnaround after reads). It drives the memory's address, a pair of chip selects of opposite polarity, one active-low enable for each byte lane, the write strobe and the output enable. The write data bus is given as separate out, drive-enable and in vectors, so a pad ring can build the three-state pin.

Every timing limit is a parameter in nanoseconds. Elaboration turns each one into a whole number of clock cycles using the clock period parameter. Every output towards the memory comes straight from a flop, so nothing glitches while the memory is selected. The write strobe falls only after the address, the selects and the byte enables have settled. The output enable stays high for the whole of a write, so the memory never drives the bus then. Read data is sampled on the last clock of the strobe phase and returned with a one-cycle done pulse.

Top module: `asram_ctrl`

## Requirements
- R1: During and right after reset: mem_cs1_n=1, mem_cs2=0, mem_byte_n=2'b11, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1, rsp_done=0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the access (and any turnaround) is over, and requests offered meanwhile do not change the memory address or the access.
- R3: The chip selects are active (mem_cs1_n=0, mem_cs2=1) from the cycle after acceptance to the end of the hold phase, and inactive at all other times.
- R4: While selected, mem_byte_n[0] (data bits 7:0) is low exactly when req_be[0]=1, and mem_byte_n[1] (bits 15:8) is low exactly when req_be[1]=1. A write with mask 2'b00 keeps both high and leaves the memory contents unchanged. A partial mask leaves the other byte unchanged.
- R5: A write holds mem_we_n high during setup and then low for the write strobe count. mem_dq_oe=1 and mem_dq_out equals the write data throughout the strobe. mem_we_n is low only while the chip is selected.
- R6: A read holds mem_oe_n low for the read strobe count with mem_we_n high. It samples mem_dq_in on the last clock of that window and presents the value on rsp_rdata while rsp_done=1. mem_we_n and mem_oe_n are never both low.
- R7: rsp_done is a one-cycle pulse, given once for each access (read or write), in the cycle after the strobe phase ends.
- R8: After a read, mem_oe_n rises, then one hold cycle and the turnaround count pass before req_ready returns (6 cycles with the bench values). mem_dq_oe is never 1 while mem_oe_n=0.
- R9: Each phase count is the ceiling of its limit over CLK_NS, with a minimum of 1. Setup covers address setup. The write strobe covers the strobe width, the data setup time and the address-to-strobe-end time less setup. The read strobe covers the output-enable access time and the address access time less setup. Hold is stretched so the three phases reach the cycle time. Turnaround covers the output release time.
- R10: mem_addr stays constant for the whole time the chip is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done after a read |
| mem_addr | output | 18 | Memory address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_byte_n | output | 2 | Byte lane enables, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The bench builds the controller with a 4 ns clock and the fast-grade limits. These give a 1-cycle setup, a 12-cycle write strobe (the address-to-strobe-end limit sets it), a 13-cycle read strobe (address access less setup), a 1-cycle hold and a 5-cycle turnaround. The bench computes the same counts from the nanosecond values with its own ceiling function. It counts the strobe, select and busy cycles of each access against them. A small bench memory that decodes the low address bits makes byte-mask merging, the empty mask and requests offered while busy visible through later reads.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_TURN
  } phase_e;

  // Cycles needed to cover ns at a clock of clk_ns: ceiling, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Time left after a part already covered by earlier phases, never negative.
  function automatic int ns_left(input int ns, input int spent_ns);
    return (ns > spent_ns) ? (ns - spent_ns) : 0;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int BE_W      = 2,
  parameter int SETUP_CYC = 1,
  parameter int WSTRB_CYC = 12,
  parameter int RSTRB_CYC = 13,
  parameter int WHOLD_CYC = 1,
  parameter int RHOLD_CYC = 1,
  parameter int TURN_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  output phase_e            nxt_phase,
  output logic              nxt_write,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic [DATA_W-1:0] nxt_wdata,
  output logic [BE_W-1:0]   nxt_be,
  output logic              strobe_end,
  output logic              cap_read
);

  localparam int MAX_CYC = imax(imax(imax(SETUP_CYC, WSTRB_CYC), imax(RSTRB_CYC, WHOLD_CYC)),
                                imax(RHOLD_CYC, TURN_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  function automatic logic [CNT_W-1:0] span(input int n);
    return CNT_W'(n - 1);
  endfunction

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              op_write_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [BE_W-1:0]   op_be_q;

  // Named internal events
  logic accept;
  logic phase_last;

  assign req_ready  = (ph_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign phase_last = (cnt_q == '0);
  assign strobe_end = (ph_q == ST_STROBE) && phase_last;
  assign cap_read   = strobe_end && !op_write_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    unique case (ph_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          ph_d  = ST_SETUP;
          cnt_d = span(SETUP_CYC);
        end
      end
      ST_SETUP: if (phase_last) begin
        ph_d  = ST_STROBE;
        cnt_d = op_write_q ? span(WSTRB_CYC) : span(RSTRB_CYC);
      end
      ST_STROBE: if (phase_last) begin
        ph_d  = ST_HOLD;
        cnt_d = op_write_q ? span(WHOLD_CYC) : span(RHOLD_CYC);
      end
      ST_HOLD: if (phase_last) begin
        if (op_write_q) begin
          ph_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          ph_d  = ST_TURN;
          cnt_d = span(TURN_CYC);
        end
      end
      ST_TURN: if (phase_last) begin
        ph_d  = ST_IDLE;
        cnt_d = '0;
      end
      default: begin
        ph_d  = ST_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= ST_IDLE;
      cnt_q      <= '0;
      op_write_q <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      op_be_q    <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (accept) begin
        op_write_q <= req_write;
        op_addr_q  <= req_addr;
        op_wdata_q <= req_wdata;
        op_be_q    <= req_be;
      end
    end
  end

  // The pin stage registers these, so they carry the fields of the access in the next cycle.
  assign nxt_phase = ph_d;
  assign nxt_write = accept ? req_write : op_write_q;
  assign nxt_addr  = accept ? req_addr  : op_addr_q;
  assign nxt_wdata = accept ? req_wdata : op_wdata_q;
  assign nxt_be    = accept ? req_be    : op_be_q;

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2

  AST_BUSY_HOLDS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(op_addr_q)); // R2

  AST_STROBE_FOLLOWS_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == ST_SETUP && phase_last) |=> (ph_q == ST_STROBE)); // R9

endmodule

// File: rtl/asram_phy.sv
module asram_phy
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int BE_W      = 2,
  parameter int WSTRB_CYC = 12,
  parameter int TURN_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            nxt_phase,
  input  logic              nxt_write,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic [DATA_W-1:0] nxt_wdata,
  input  logic [BE_W-1:0]   nxt_be,
  input  logic              strobe_end,
  input  logic              cap_read,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic [BE_W-1:0]   mem_byte_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int WCNT_W = $clog2(WSTRB_CYC + 2);
  localparam int QCNT_W = $clog2(TURN_CYC + 2);

  // Named decode of the coming cycle
  logic            sel_d;
  logic            we_d;
  logic            oe_d;
  logic            drive_d;
  logic [BE_W-1:0] byte_d;

  assign sel_d   = (nxt_phase == ST_SETUP) || (nxt_phase == ST_STROBE) || (nxt_phase == ST_HOLD);
  assign we_d    = (nxt_phase == ST_STROBE) && nxt_write;
  assign oe_d    = (nxt_phase == ST_STROBE) && !nxt_write;
  assign drive_d = sel_d && nxt_write;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign byte_d[g] = !(sel_d && nxt_be[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_cs1_n  <= 1'b1;
      mem_cs2    <= 1'b0;
      mem_byte_n <= '1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      if (sel_d) mem_addr <= nxt_addr;
      mem_cs1_n  <= !sel_d;
      mem_cs2    <= sel_d;
      mem_byte_n <= byte_d;
      mem_we_n   <= !we_d;
      mem_oe_n   <= !oe_d;
      if (drive_d) mem_dq_out <= nxt_wdata;
      mem_dq_oe  <= drive_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= strobe_end;
      if (cap_read) rsp_rdata <= mem_dq_in;
    end
  end

  // Observation counters that the assertions below use
  logic [WCNT_W-1:0] we_low_cnt;
  logic [QCNT_W-1:0] oe_quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      oe_quiet   <= QCNT_W'(TURN_CYC + 1);
    end else begin
      if (mem_we_n) we_low_cnt <= '0;
      else if (we_low_cnt != WCNT_W'(WSTRB_CYC + 1)) we_low_cnt <= we_low_cnt + 1'b1;
      if (!mem_oe_n) oe_quiet <= '0;
      else if (oe_quiet != QCNT_W'(TURN_CYC + 1)) oe_quiet <= oe_quiet + 1'b1;
    end
  end

  AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs1_n && mem_cs2 && (mem_byte_n != '1 || $past(mem_byte_n) == mem_byte_n))); // R5

  AST_WE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs1_n && mem_cs2)); // R5

  AST_BYTE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_byte_n != '1) |-> (!mem_cs1_n && mem_cs2)); // R4

  AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R6

  AST_NO_DRIVE_UNDER_OE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R8

  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_quiet >= QCNT_W'(TURN_CYC))); // R8

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == WCNT_W'(WSTRB_CYC))); // R9

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs1_n && $past(!mem_cs1_n)) |-> $stable(mem_addr)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R7

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int CLK_NS        = 4,
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int T_ADDR_SU_NS  = 0,
  parameter int T_ADDR_WR_NS  = 50,
  parameter int T_WR_PULSE_NS = 45,
  parameter int T_DATA_SU_NS  = 30,
  parameter int T_DATA_HD_NS  = 0,
  parameter int T_CYCLE_NS    = 55,
  parameter int T_ADDR_ACC_NS = 55,
  parameter int T_OE_ACC_NS   = 30,
  parameter int T_OE_REL_NS   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_cs1_n,
  output logic                mem_cs2,
  output logic [DATA_W/8-1:0] mem_byte_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int BE_W      = DATA_W / 8;
  localparam int SETUP_CYC = ns_to_cyc(T_ADDR_SU_NS, CLK_NS);
  localparam int SETUP_NS  = SETUP_CYC * CLK_NS;
  localparam int WSTRB_CYC = imax(imax(ns_to_cyc(T_WR_PULSE_NS, CLK_NS), ns_to_cyc(T_DATA_SU_NS, CLK_NS)),
                                  ns_to_cyc(ns_left(T_ADDR_WR_NS, SETUP_NS), CLK_NS));
  localparam int RSTRB_CYC = imax(ns_to_cyc(T_OE_ACC_NS, CLK_NS),
                                  ns_to_cyc(ns_left(T_ADDR_ACC_NS, SETUP_NS), CLK_NS));
  localparam int CYC_ALL   = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int WHOLD_CYC = imax(ns_to_cyc(T_DATA_HD_NS, CLK_NS), CYC_ALL - SETUP_CYC - WSTRB_CYC);
  localparam int RHOLD_CYC = imax(1, CYC_ALL - SETUP_CYC - RSTRB_CYC);
  localparam int TURN_CYC  = ns_to_cyc(T_OE_REL_NS, CLK_NS);

  phase_e            nxt_phase;
  logic              nxt_write;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_wdata;
  logic [BE_W-1:0]   nxt_be;
  logic              strobe_end;
  logic              cap_read;

  asram_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
    .SETUP_CYC(SETUP_CYC), .WSTRB_CYC(WSTRB_CYC), .RSTRB_CYC(RSTRB_CYC),
    .WHOLD_CYC(WHOLD_CYC), .RHOLD_CYC(RHOLD_CYC), .TURN_CYC(TURN_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .nxt_phase(nxt_phase), .nxt_write(nxt_write), .nxt_addr(nxt_addr),
    .nxt_wdata(nxt_wdata), .nxt_be(nxt_be),
    .strobe_end(strobe_end), .cap_read(cap_read)
  );

  asram_phy #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
    .WSTRB_CYC(WSTRB_CYC), .TURN_CYC(TURN_CYC)
  ) u_phy (
    .clk(clk), .rst_n(rst_n),
    .nxt_phase(nxt_phase), .nxt_write(nxt_write), .nxt_addr(nxt_addr),
    .nxt_wdata(nxt_wdata), .nxt_be(nxt_be),
    .strobe_end(strobe_end), .cap_read(cap_read), .mem_dq_in(mem_dq_in),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
    .mem_byte_n(mem_byte_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  AST_PHASE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs1_n) |-> req_ready || !mem_oe_n || mem_we_n); // R3

endmodule

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int CLK_NS = 4;

  function automatic int cyc(input int ns);
    int c;
    c = ns / CLK_NS;
    if (c * CLK_NS < ns) c = c + 1;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SETUP = cyc(0);
  localparam int E_WSTRB = mx(mx(cyc(45), cyc(30)), cyc(50 - E_SETUP * CLK_NS));
  localparam int E_RSTRB = mx(cyc(30), cyc(55 - E_SETUP * CLK_NS));
  localparam int E_WHOLD = mx(1, cyc(55) - E_SETUP - E_WSTRB);
  localparam int E_RHOLD = mx(1, cyc(55) - E_SETUP - E_RSTRB);
  localparam int E_TURN  = cyc(20);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_byte_n;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in;

  always #(CLK_NS / 2) clk = ~clk;

  asram_ctrl #(.CLK_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_byte_n(mem_byte_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // Bench memory: 16 words decoded from the low address bits
  logic [15:0] mdl [16];
  logic        chip_on;
  assign chip_on   = !mem_cs1_n && mem_cs2;
  assign mem_dq_in = (chip_on && !mem_oe_n && mem_we_n) ? mdl[mem_addr[3:0]] : 16'h0BAD;

  initial for (int i = 0; i < 16; i++) mdl[i] = 16'(i * 16'h0101);

  always @(posedge mem_we_n) begin
    if (rst_n && chip_on && mem_dq_oe) begin
      if (!mem_byte_n[0]) mdl[mem_addr[3:0]][7:0]  = mem_dq_out[7:0];
      if (!mem_byte_n[1]) mdl[mem_addr[3:0]][15:8] = mem_dq_out[15:8];
    end
  end

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Measurements of the last access
  int m_busy, m_sel, m_we, m_oe, m_done, m_addr_err, m_byte_err, m_wd_err, m_dq_err, m_oe2rdy;
  logic [15:0] m_rdata;

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, input bit nag);
    bit seen_oe;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    if (nag) begin
      req_write = 1'b1; req_addr = a + 18'd1; req_wdata = 16'hDEAD; req_be = 2'b11;
    end else req_valid = 1'b0;
    m_busy = 0; m_sel = 0; m_we = 0; m_oe = 0; m_done = 0; m_addr_err = 0;
    m_byte_err = 0; m_wd_err = 0; m_dq_err = 0; m_oe2rdy = 0; m_rdata = 16'h0; seen_oe = 0;
    while (!req_ready && m_busy < 200) begin
      m_busy++;
      if (chip_on) begin
        m_sel++;
        if (mem_addr != a) m_addr_err++;
        if (mem_byte_n != ~be) m_byte_err++;
      end else if (mem_byte_n != 2'b11) m_byte_err++;
      if (!mem_we_n) begin
        m_we++;
        if (!mem_dq_oe || mem_dq_out != d || !mem_oe_n) m_wd_err++;
      end
      if (!mem_oe_n) begin m_oe++; seen_oe = 1; end
      else if (seen_oe) m_oe2rdy++;
      if (mem_dq_oe && (!mem_oe_n || !wr)) m_dq_err++;
      if (rsp_done) begin m_done++; m_rdata = rsp_rdata; end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "strobes in reset", {mem_cs1_n, mem_cs2, mem_byte_n, mem_we_n, mem_oe_n, mem_dq_oe},
          7'b1011110);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "strobes after reset", {mem_cs1_n, mem_cs2, mem_byte_n, mem_we_n, mem_oe_n, mem_dq_oe},
          7'b1011110);
    check("R1", "ready/done after reset", {req_ready, rsp_done}, 2'b10);
  endtask

  task automatic t_full_write;
    access(1'b1, 18'h2_0003, 16'hA5C3, 2'b11, 1'b0);
    check("R5", "write strobe cycles", m_we, E_WSTRB);
    check("R9", "write busy cycles", m_busy, E_SETUP + E_WSTRB + E_WHOLD);
    check("R3", "write select cycles", m_sel, E_SETUP + E_WSTRB + E_WHOLD);
    check("R5", "write data/oe during strobe errors", m_wd_err, 0);
    check("R6", "oe low during write", m_oe, 0);
    check("R7", "done pulses on write", m_done, 1);
    check("R10", "address changes while selected", m_addr_err, 0);
    check("R4", "byte enable mismatch full write", m_byte_err, 0);
  endtask

  task automatic t_read(input logic [17:0] a, input logic [15:0] exp, input string req);
    access(1'b0, a, 16'h0, 2'b11, 1'b0);
    check(req, "read data", m_rdata, exp);
    check("R7", "done pulses on read", m_done, 1);
  endtask

  task automatic t_read_timing;
    access(1'b0, 18'h2_0003, 16'h0, 2'b11, 1'b0);
    check("R6", "read oe cycles", m_oe, E_RSTRB);
    check("R6", "we low during read", m_we, 0);
    check("R6", "read data", m_rdata, 16'hA5C3);
    check("R8", "oe release to ready", m_oe2rdy, E_RHOLD + E_TURN);
    check("R8", "bus driven during read", m_dq_err, 0);
    check("R9", "read busy cycles", m_busy, E_SETUP + E_RSTRB + E_RHOLD + E_TURN);
    check("R3", "read select cycles", m_sel, E_SETUP + E_RSTRB + E_RHOLD);
  endtask

  task automatic t_byte_masks;
    access(1'b1, 18'h2_0003, 16'h1111, 2'b01, 1'b0);
    check("R4", "low byte mask enables", m_byte_err, 0);
    t_read(18'h2_0003, 16'hA511, "R4");
    access(1'b1, 18'h2_0003, 16'h2222, 2'b10, 1'b0);
    check("R4", "high byte mask enables", m_byte_err, 0);
    t_read(18'h2_0003, 16'h2211, "R4");
    access(1'b1, 18'h2_0003, 16'hFFFF, 2'b00, 1'b0);
    check("R4", "empty mask keeps both high", m_byte_err, 0);
    t_read(18'h2_0003, 16'h2211, "R4");
  endtask

  task automatic t_busy_requests;
    access(1'b1, 18'h0_0005, 16'h5A5A, 2'b11, 1'b1);
    check("R2", "address disturbed by busy request", m_addr_err, 0);
    check("R2", "busy length with request held", m_busy, E_SETUP + E_WSTRB + E_WHOLD);
    t_read(18'h0_0006, 16'h0606, "R2");
    t_read(18'h0_0005, 16'h5A5A, "R2");
  endtask

  initial begin
    t_reset();
    t_full_write();
    t_read_timing();
    t_byte_masks();
    t_busy_requests();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * CLK_NS);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule